// File: doc/BRIEF.md
# Hardware Key Slot Controller

This block keeps three key slots that only hardware can read: one for an AES engine, one for a KMAC engine and one for a big-number accelerator, called OTBN below. A derivation engine fills a slot when it produces a hardware output. It does this with a one-cycle load strobe that carries a destination code and the key data. Each slot presents its key together with a valid flag, and the consuming engines read them directly.

Software can scrub the slots through a 3-bit clear selector. Once a code is selected, the scrubbing is continuous: on every clock the chosen slot, or every slot, is rewritten with the current entropy word. The entropy word is replicated across the whole slot width. The scrubbing lasts for as long as the selector holds that code.

The stage controller also drives the block through two indications:
- Disabled freezes loading, but the slots and their flags are kept.
- Invalid wipes every slot to zero and drops every valid flag.

Top module: `keyslot_ctrl`

## Requirements
- R1: Clear code 0 clears no slot. Code 1 clears only the AES slot, code 2 only the KMAC slot and code 3 only the OTBN slot.
- R2: While a slot is cleared, its key is rewritten on every clock with the entropy word of that cycle, replicated across the slot (8 copies for 256 bits, 12 copies for 384 bits).
- R3: Clear codes 4, 5, 6 and 7 clear all three slots at once.
- R4: When the clear code changes to 0 or to a code that no longer covers a slot, that slot stops changing. It keeps the last entropy value written and stays invalid until it is loaded again.
- R5: The OTBN slot is 384 bits wide and takes all of `load_key_i`. The AES and KMAC slots are 256 bits wide and take `load_key_i[255:0]`.
- R6: A load with destination 1 (AES), 2 (KMAC) or 3 (OTBN) writes only that slot and sets its valid flag. Destination 0 changes nothing.
- R7: A slot's valid flag is low for as long as that slot is being cleared.
- R8: If a load and a clear target the same slot in the same cycle, the clear wins: the slot takes entropy and its valid flag stays low. A load to a slot that is not being cleared still takes effect.
- R9: While `st_disabled_i` is high, loads are ignored, and slot contents and valid flags are kept unless a clear selects them.
- R10: While `st_invalid_i` is high, every slot holds zero and every valid flag is low. This overrides both loads and clears.
- R11: After reset, all slots are zero and all valid flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_sel_i | input | 3 | Continuous clear selector |
| load_i | input | 1 | Load strobe from the derivation engine |
| load_dest_i | input | 2 | Load destination: 0 none, 1 AES, 2 KMAC, 3 OTBN |
| load_key_i | input | 384 | Key data for a load |
| entropy_i | input | 32 | Entropy word used for clearing |
| st_disabled_i | input | 1 | Stage controller is in Disabled |
| st_invalid_i | input | 1 | Stage controller is in Invalid |
| aes_key_o | output | 256 | AES slot key |
| aes_valid_o | output | 1 | AES slot valid |
| kmac_key_o | output | 256 | KMAC slot key |
| kmac_valid_o | output | 1 | KMAC slot valid |
| otbn_key_o | output | 384 | OTBN slot key |
| otbn_valid_o | output | 1 | OTBN slot valid |

## Verification
Each slot has a single register stage. A load, a clear step, an Invalid wipe or the end of a clear therefore shows at the outputs right after the first rising edge that sees the stimulus. No result arrives later than that edge.

The bench changes inputs only on falling edges and compares outputs at the next falling edge. This places every sample half a period after the edge that made the result.

The expected values come from a bench model that applies the requirements cycle by cycle. This lets the bench check, in the sample after they end, that a stopped clear left entropy in place and that an ignored load changed nothing.

// File: rtl/keyslot_pkg.sv
package keyslot_pkg;
    localparam int NUM_SLOTS = 3;
    localparam int CLR_W     = 3;
    localparam int DEST_W    = 2;

    localparam int SLOT_AES  = 0;
    localparam int SLOT_KMAC = 1;
    localparam int SLOT_OTBN = 2;

    typedef enum logic [DEST_W-1:0] {
        DEST_NONE = 2'd0,
        DEST_AES  = 2'd1,
        DEST_KMAC = 2'd2,
        DEST_OTBN = 2'd3
    } dest_e;
endpackage

// File: rtl/keyslot_clear_dec.sv
module keyslot_clear_dec
    import keyslot_pkg::*;
(
    input  logic [CLR_W-1:0]     sel_i,
    output logic [NUM_SLOTS-1:0] mask_o
);
    // Code i+1 targets slot i; any code with the top bit set targets every slot.
    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_mask
        assign mask_o[i] = (sel_i == CLR_W'(i + 1)) || sel_i[CLR_W-1];
    end

    always_comb begin
        if (!$isunknown(sel_i)) begin
            if (sel_i == '0) begin
                assert_zero_code_idle_R1: assert (mask_o == '0);
            end
            if (sel_i[CLR_W-1]) begin
                assert_wide_code_all_R3: assert (&mask_o);
            end
            if (!sel_i[CLR_W-1] && sel_i != '0) begin
                assert_single_slot_R1: assert ($onehot(mask_o) && mask_o[sel_i[1:0] - 2'd1]);
            end
        end
    end
endmodule

// File: rtl/keyslot_store.sv
module keyslot_store #(
    parameter int KEY_W = 256,
    parameter int ENT_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             kill_i,
    input  logic             clr_i,
    input  logic             ld_i,
    input  logic [KEY_W-1:0] ld_key_i,
    input  logic [ENT_W-1:0] ent_i,
    output logic [KEY_W-1:0] key_o,
    output logic             valid_o
);
    // KEY_W is a whole multiple of ENT_W.
    localparam int REP = KEY_W / ENT_W;

    typedef struct packed {
        logic [KEY_W-1:0] key;
        logic             valid;
    } slot_t;

    slot_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (kill_i) begin
            s_d.key   = '0;
            s_d.valid = 1'b0;
        end else if (clr_i) begin
            s_d.key   = {REP{ent_i}};
            s_d.valid = 1'b0;
        end else if (ld_i) begin
            s_d.key   = ld_key_i;
            s_d.valid = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign key_o   = s_q.key;
    assign valid_o = s_q.valid;

    assert_invalid_wipe_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        kill_i |=> (!valid_o && key_o == '0));

    assert_clear_entropy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_i && !kill_i) |=> (key_o == {REP{$past(ent_i)}}));

    assert_clear_no_valid_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_i && !kill_i) |=> !valid_o);

    assert_clear_beats_load_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_i && ld_i && !kill_i) |=> !valid_o);

    assert_load_sets_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ld_i && !clr_i && !kill_i) |=> (valid_o && key_o == $past(ld_key_i)));

    assert_idle_holds_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!ld_i && !clr_i && !kill_i) |=> ($stable(key_o) && $stable(valid_o)));
endmodule

// File: rtl/keyslot_ctrl.sv
module keyslot_ctrl
    import keyslot_pkg::*;
#(
    parameter int STD_W  = 256,
    parameter int WIDE_W = 384,
    parameter int ENT_W  = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [CLR_W-1:0]  clear_sel_i,
    input  logic              load_i,
    input  logic [DEST_W-1:0] load_dest_i,
    input  logic [WIDE_W-1:0] load_key_i,
    input  logic [ENT_W-1:0]  entropy_i,
    input  logic              st_disabled_i,
    input  logic              st_invalid_i,
    output logic [STD_W-1:0]  aes_key_o,
    output logic              aes_valid_o,
    output logic [STD_W-1:0]  kmac_key_o,
    output logic              kmac_valid_o,
    output logic [WIDE_W-1:0] otbn_key_o,
    output logic              otbn_valid_o
);
    logic [NUM_SLOTS-1:0] clr_mask;
    logic [NUM_SLOTS-1:0] ld_vec;

    keyslot_clear_dec u_dec (
        .sel_i  (clear_sel_i),
        .mask_o (clr_mask)
    );

    // Loads are ignored while the stage controller is in Disabled.
    always_comb begin
        for (int i = 0; i < NUM_SLOTS; i++) begin
            ld_vec[i] = load_i && !st_disabled_i && (load_dest_i == DEST_W'(i + 1));
        end
    end

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        localparam int W = (i == SLOT_OTBN) ? WIDE_W : STD_W;
        logic [W-1:0] slot_key;
        logic         slot_vld;

        keyslot_store #(.KEY_W(W), .ENT_W(ENT_W)) u_store (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .kill_i   (st_invalid_i),
            .clr_i    (clr_mask[i]),
            .ld_i     (ld_vec[i]),
            .ld_key_i (load_key_i[W-1:0]),
            .ent_i    (entropy_i),
            .key_o    (slot_key),
            .valid_o  (slot_vld)
        );

        if (i == SLOT_AES) begin : g_aes
            assign aes_key_o   = slot_key;
            assign aes_valid_o = slot_vld;
        end else if (i == SLOT_KMAC) begin : g_kmac
            assign kmac_key_o   = slot_key;
            assign kmac_valid_o = slot_vld;
        end else begin : g_otbn
            assign otbn_key_o   = slot_key;
            assign otbn_valid_o = slot_vld;
        end
    end

    assert_disabled_freeze_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_disabled_i && !st_invalid_i && clear_sel_i == '0) |=>
        ($stable(aes_key_o) && $stable(kmac_key_o) && $stable(otbn_key_o) &&
         $stable(aes_valid_o) && $stable(kmac_valid_o) && $stable(otbn_valid_o)));

    assert_dest_none_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (load_i && load_dest_i == DEST_NONE && !st_invalid_i && clear_sel_i == '0) |=>
        ($stable(aes_key_o) && $stable(kmac_key_o) && $stable(otbn_key_o)));

    assert_invalid_flags_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_invalid_i |=> (!aes_valid_o && !kmac_valid_o && !otbn_valid_o));
endmodule

// File: tb/keyslot_ctrl_bench.sv
module keyslot_ctrl_bench;
    logic         clk = 1'b0;
    logic         rst_ni = 1'b0;
    logic [2:0]   clear_sel = '0;
    logic         load = 1'b0;
    logic [1:0]   dest = '0;
    logic [383:0] key_in = '0;
    logic [31:0]  ent = '0;
    logic         dis = 1'b0;
    logic         inv = 1'b0;
    logic [255:0] aes_key, kmac_key;
    logic [383:0] otbn_key;
    logic         aes_v, kmac_v, otbn_v;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [383:0] e_key [3];
    logic         e_vld [3];

    always #2 clk = ~clk;

    keyslot_ctrl u_keyslot_ctrl (
        .clk_i(clk), .rst_ni(rst_ni), .clear_sel_i(clear_sel), .load_i(load),
        .load_dest_i(dest), .load_key_i(key_in), .entropy_i(ent),
        .st_disabled_i(dis), .st_invalid_i(inv),
        .aes_key_o(aes_key), .aes_valid_o(aes_v),
        .kmac_key_o(kmac_key), .kmac_valid_o(kmac_v),
        .otbn_key_o(otbn_key), .otbn_valid_o(otbn_v)
    );

    task automatic check(input bit ok, input string tag, input logic [383:0] act, input logic [383:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        check(aes_key == e_key[0][255:0], {tag, " aes key"}, 384'(aes_key), e_key[0]);
        check(kmac_key == e_key[1][255:0], {tag, " kmac key"}, 384'(kmac_key), e_key[1]);
        check(otbn_key == e_key[2], {tag, " otbn key"}, otbn_key, e_key[2]);
        check(aes_v == e_vld[0], {tag, " aes valid"}, 384'(aes_v), 384'(e_vld[0]));
        check(kmac_v == e_vld[1], {tag, " kmac valid"}, 384'(kmac_v), 384'(e_vld[1]));
        check(otbn_v == e_vld[2], {tag, " otbn valid"}, 384'(otbn_v), 384'(e_vld[2]));
    endtask

    // Requirement model: one clock edge, then the falling edge where outputs are sampled.
    task automatic cyc();
        logic [383:0] nk [3];
        logic         nv [3];
        for (int s = 0; s < 3; s++) begin
            bit clr = (clear_sel == 3'(s + 1)) || clear_sel[2];
            bit ld  = load && !dis && (dest == 2'(s + 1));
            nk[s] = e_key[s];
            nv[s] = e_vld[s];
            if (inv) begin
                nk[s] = '0; nv[s] = 1'b0;
            end else if (clr) begin
                nk[s] = (s == 2) ? {12{ent}} : {128'd0, {8{ent}}};
                nv[s] = 1'b0;
            end else if (ld) begin
                nk[s] = (s == 2) ? key_in : {128'd0, key_in[255:0]};
                nv[s] = 1'b1;
            end
        end
        @(negedge clk);
        for (int s = 0; s < 3; s++) begin
            e_key[s] = nk[s];
            e_vld[s] = nv[s];
        end
    endtask

    task automatic do_load(input logic [1:0] d, input logic [383:0] k);
        load = 1'b1; dest = d; key_in = k;
        cyc();
        load = 1'b0;
    endtask

    task automatic t_reset();
        for (int s = 0; s < 3; s++) begin e_key[s] = '0; e_vld[s] = 1'b0; end
        repeat (3) @(negedge clk);
        rst_ni = 1'b1;
        @(negedge clk);
        check_all("R11 reset");
    endtask

    task automatic t_load();
        do_load(2'd1, {12{32'hA1A1_0001}});
        check_all("R6 R5 load aes low 256");
        do_load(2'd3, {32'hFEED_0003, 352'h1234_5678_9ABC_DEF0_1357_9BDF_2468_ACE0_0F0F_F0F0_3C3C_C3C3_5A5A_A5A5_1111_2222_3333_4444_5555_6666_7777_8888});
        check_all("R5 R6 load otbn 384");
        do_load(2'd2, {12{32'hB2B2_0002}});
        check_all("R6 load kmac");
        do_load(2'd0, {12{32'hDEAD_0000}});
        check_all("R6 dest 0 no change");
    endtask

    task automatic t_clear_one();
        clear_sel = 3'd1; ent = 32'hC001_0001;
        cyc();
        check_all("R1 R2 R7 clear aes only");
        ent = 32'hC001_0002;
        cyc();
        check_all("R2 every cycle new entropy");
        clear_sel = 3'd0; ent = 32'hC001_0003;
        cyc();
        check_all("R4 clear stop keeps entropy");
        cyc();
        check_all("R4 held invalid");
        clear_sel = 3'd3; ent = 32'hC003_0001;
        cyc();
        check_all("R1 clear otbn only");
        clear_sel = 3'd2; ent = 32'hC002_0001;
        cyc();
        check_all("R1 R4 switch to kmac");
        clear_sel = 3'd0;
        do_load(2'd1, {12{32'h0A0A_1111}});
        do_load(2'd2, {12{32'h0B0B_2222}});
        do_load(2'd3, {12{32'h0C0C_3333}});
        check_all("R6 reload");
    endtask

    task automatic t_clear_all();
        for (int c = 4; c < 8; c++) begin
            clear_sel = 3'(c); ent = 32'hE000_0000 | 32'(c);
            cyc();
            check_all("R3 wide code clears all");
        end
        clear_sel = 3'd2; ent = 32'hE222_0000;
        cyc();
        check_all("R4 R1 narrow to kmac");
        clear_sel = 3'd0;
        do_load(2'd1, {12{32'h1A1A_0101}});
        do_load(2'd3, {12{32'h1C1C_0303}});
        check_all("R6 reload after wide clear");
    endtask

    task automatic t_collide();
        clear_sel = 3'd3; ent = 32'h5EED_0003;
        do_load(2'd3, {12{32'h7777_0003}});
        check_all("R8 clear beats load otbn");
        do_load(2'd1, {12{32'h7777_0001}});
        check_all("R8 load other slot proceeds");
        clear_sel = 3'd0;
        do_load(2'd3, {12{32'h7777_3333}});
        check_all("R6 otbn reload");
    endtask

    task automatic t_disabled();
        dis = 1'b1;
        do_load(2'd1, {12{32'hBAD0_0001}});
        check_all("R9 load ignored in disabled");
        repeat (3) cyc();
        check_all("R9 slots kept in disabled");
        clear_sel = 3'd2; ent = 32'hD15A_0002;
        cyc();
        check_all("R9 clear acts in disabled");
        clear_sel = 3'd0; dis = 1'b0;
        do_load(2'd2, {12{32'h2B2B_0202}});
        check_all("R6 load after disabled");
    endtask

    task automatic t_invalid();
        inv = 1'b1;
        do_load(2'd1, {12{32'h9999_0001}});
        check_all("R10 invalid wipes, load ignored");
        clear_sel = 3'd7; ent = 32'h4444_4444;
        cyc();
        check_all("R10 invalid overrides clear");
        clear_sel = 3'd0;
        cyc();
        check_all("R10 invalid held");
    endtask

    initial begin
        t_reset();
        t_load();
        t_clear_one();
        t_clear_all();
        t_collide();
        t_disabled();
        t_invalid();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule